// File: doc/BRIEF.md
# Removable Storage Card Host Bus Decoder

This block sits on the card side of a parallel host bus for a removable storage card. It follows a PC Card style memory/I-O protocol and can fall back to a True IDE register interface. Every host strobe and chip enable passes through a two-flop synchroniser into the system clock. The block then steers the two byte lanes of the 16-bit data bus and produces select, byte-enable, read and write controls for a small internal register file. It also drives the status pins: ready/busy or interrupt, write-protect or 16-bit indication, card detect and battery/speaker.

The operating mode is held by a four-state machine. `ST_BUSY` is entered on reset and lasts `BUSY_CYCLES` clocks. At the end of that count, the machine takes transition T1 to `ST_MEM` if the synchronised output-enable is high, or transition T2 to `ST_IDE` if it is low. From `ST_MEM`, transition T3 moves to `ST_IO` when `io_cfg` is set. From `ST_IO`, transition T4 returns to `ST_MEM` when `io_cfg` clears. `ST_IDE` only leaves on reset.

A register-file word index is 4 bits wide. In memory and I/O modes the index is `host_addr[4:1]`. In True IDE mode the index is `host_addr[2:0]` for task-file registers, and index 8 for the alternate-status/device-control register.

Top module: `cfbus_decoder`

## Requirements
- R1: While `rst_n` is low, and for `BUSY_CYCLES` clocks after it rises, the machine is in `ST_BUSY`. In that state `rdy_irq` is 0, `wp_iois16_n` is 1, and no read or write enable is given. After that, in memory mode, `rdy_irq` is 1.
- R2: If the synchronised output-enable is low when the busy count ends, the block enters True IDE mode (`ide_mode`=1) and stays there until reset, whatever `io_cfg` does. Otherwise it enters memory mode. In memory mode `io_cfg`=1 selects I/O mode, and `io_cfg`=0 returns to memory mode.
- R3: Lane steering, with chip enables active low:
  - CE1 and CE2 both low: a word access, `rf_be`=11.
  - CE1 low alone with A0=0: the even byte on D[7:0], `rf_be`=01.
  - CE1 low alone with A0=1: the odd byte moved to D[7:0], `rf_be`=10. Write data bits [7:0] are copied to `rf_wdata[15:8]`, and read data bits [15:8] appear on `host_rdata[7:0]`.
  - CE2 low alone: the odd byte on D[15:8], `rf_be`=10.
- R4: In memory and I/O modes, output-enable or write-enable with `host_reg_n`=0 is an attribute access (`rf_attr`=1). It is accepted only when CE1 is low and A0=0, with `rf_be`=01. Odd addresses, and CE2-only accesses, are ignored.
- R5: A write (write-enable or I/O write) produces a single-cycle `rf_we` pulse after the synchronised strobe returns high, never while the strobe is low. The address and lanes are those decoded at that time.
- R6: `data_oe` and `rf_re` are high only while a read strobe is low and the selection is valid. An access with both chip enables high is ignored.
- R7: I/O read and I/O write strobes are ignored in memory mode. In I/O mode they need `host_reg_n`=0 and use the same lane steering as R3.
- R8: In True IDE mode:
  - CE1 low alone selects task-file index A[2:0]. Index 0 is a 16-bit word (`rf_be`=11); every other index uses D[7:0] only (`rf_be`=01).
  - CE2 low alone selects index 8 with `rf_be`=01.
  - Both chip enables low is ignored.
  - Write-enable, REG and output-enable have no effect.
- R9: `wp_iois16_n` behaves as follows:
  - It is 0 in memory mode.
  - In I/O mode it is 0 while both chip enables are low, `host_reg_n`=0 and the index is 0.
  - In True IDE mode it is 0 while CE1 alone is low with A[2:0]=0.
  - It is 1 in all other cases.
- R10: `rdy_irq` carries the interrupt, one clock after `irq_req` changes:
  - In I/O level mode (`irq_pulse_mode`=0) it is the inverse of `irq_req`.
  - In I/O pulse mode it goes low for exactly one clock on each rising edge of `irq_req`.
  - In True IDE mode it equals `irq_req` (active high).
- R11: `cd_n` is always 00 and `bvd_spkr` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (host reset) |
| host_ce1_n | input | 1 | Chip enable, even byte / task file (active low) |
| host_ce2_n | input | 1 | Chip enable, odd byte / alternate register (active low) |
| host_oe_n | input | 1 | Memory read strobe; low at reset release selects IDE |
| host_we_n | input | 1 | Memory write strobe |
| host_iord_n | input | 1 | I/O read strobe |
| host_iowr_n | input | 1 | I/O write strobe, captured on trailing edge |
| host_reg_n | input | 1 | Attribute/I-O space select (active low) |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Lane-steered read data to host |
| data_oe | output | 1 | Read data drive enable |
| io_cfg | input | 1 | Configured-for-I/O indication |
| irq_req | input | 1 | Interrupt request from the card core |
| irq_pulse_mode | input | 1 | 1 = pulse interrupt, 0 = level interrupt (I/O mode) |
| rf_addr | output | 4 | Register-file word index |
| rf_be | output | 2 | Register-file byte enables |
| rf_attr | output | 1 | Access targets attribute space |
| rf_re | output | 1 | Register read enable |
| rf_we | output | 1 | Register write pulse |
| rf_wdata | output | 16 | Steered write data |
| rf_rdata | input | 16 | Register read data |
| rdy_irq | output | 1 | Ready/busy or interrupt pin |
| wp_iois16_n | output | 1 | Write-protect or 16-bit transfer indication |
| cd_n | output | 2 | Card detect pins |
| bvd_spkr | output | 1 | Battery/speaker status pin |
| ide_mode | output | 1 | True IDE mode latched |

## Verification
In True IDE mode the output-enable is held permanently low, so a standing memory-read strobe and an I/O read of the task file are present in the same cycle. The bench keeps output-enable low throughout every IDE access. It judges that `data_oe`, the index and the byte enables follow only the I/O read decode. An idle check in that mode confirms that output-enable alone never enables data. In the same way, a write-enable pulse issued in IDE mode while CE1 is selected must produce no write.

// File: rtl/cfbus_pkg.sv
package cfbus_pkg;

    localparam int RF_AW   = 4;
    localparam int DATA_W  = 16;
    localparam logic [RF_AW-1:0] ALT_IDX = 4'd8;

    typedef enum logic [1:0] {
        ST_BUSY = 2'd0,
        ST_MEM  = 2'd1,
        ST_IO   = 2'd2,
        ST_IDE  = 2'd3
    } cf_state_e;

    typedef struct packed {
        logic             valid;
        logic             attr;
        logic             word_reg;
        logic             swap;
        logic [1:0]       be;
        logic [RF_AW-1:0] idx;
    } cf_sel_t;

    // byte-lane steering from the two enables and A0
    function automatic cf_sel_t steer(input logic ce1_n, input logic ce2_n,
                                      input logic a0, input logic [RF_AW-1:0] idx);
        cf_sel_t s;
        s       = '0;
        s.idx   = idx;
        s.valid = 1'b1;
        if (!ce1_n && !ce2_n) begin
            s.be = 2'b11;
        end else if (!ce1_n) begin
            s.be   = a0 ? 2'b10 : 2'b01;
            s.swap = a0;
        end else if (!ce2_n) begin
            s.be = 2'b10;
        end else begin
            s.valid = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/cfbus_sync.sv
module cfbus_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '1;
            q    <= '1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cfbus_ctrl.sv
module cfbus_ctrl
    import cfbus_pkg::*;
#(
    parameter int BUSY_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      oe_sync_n,
    input  logic      io_cfg,
    output cf_state_e state
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(BUSY_CYCLES - 1);

    cf_state_e     state_n;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BUSY;
            cnt   <= '0;
        end else begin
            state <= state_n;
            if (state == ST_BUSY) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_BUSY: if (cnt == LAST) state_n = oe_sync_n ? ST_MEM : ST_IDE;
            ST_MEM:  if (io_cfg)      state_n = ST_IO;
            ST_IO:   if (!io_cfg)     state_n = ST_MEM;
            ST_IDE:                   state_n = ST_IDE;
            default:                  state_n = ST_BUSY;
        endcase
    end

    assert_ide_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDE) |=> (state == ST_IDE));

    assert_busy_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && cnt != LAST) |=> (state == ST_BUSY));
endmodule

// File: rtl/cfbus_decode.sv
module cfbus_decode
    import cfbus_pkg::*;
#(
    parameter int IO_KIND = 0
) (
    input  cf_state_e  state,
    input  logic       ce1_n,
    input  logic       ce2_n,
    input  logic       reg_n,
    input  logic [4:0] addr,
    output cf_sel_t    sel
);
    generate
        if (IO_KIND == 0) begin : g_mem
            always_comb begin
                sel = '0;
                if (state == ST_MEM || state == ST_IO) begin
                    if (!reg_n) begin
                        sel.idx   = addr[4:1];
                        sel.attr  = 1'b1;
                        sel.be    = 2'b01;
                        sel.valid = !ce1_n && !addr[0];
                    end else begin
                        sel = steer(ce1_n, ce2_n, addr[0], addr[4:1]);
                    end
                end
            end
        end else begin : g_io
            always_comb begin
                sel = '0;
                if (state == ST_IO) begin
                    if (!reg_n) begin
                        sel = steer(ce1_n, ce2_n, addr[0], addr[4:1]);
                        sel.word_reg = !ce1_n && !ce2_n && (addr[4:1] == 4'd0);
                    end
                end else if (state == ST_IDE) begin
                    if (!ce1_n && ce2_n) begin
                        sel.valid    = 1'b1;
                        sel.idx      = {1'b0, addr[2:0]};
                        sel.word_reg = (addr[2:0] == 3'd0);
                        sel.be       = (addr[2:0] == 3'd0) ? 2'b11 : 2'b01;
                    end else if (ce1_n && !ce2_n) begin
                        sel.valid = 1'b1;
                        sel.idx   = ALT_IDX;
                        sel.be    = 2'b01;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cfbus_decoder.sv
module cfbus_decoder
    import cfbus_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int BUSY_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ce1_n,
    input  logic              host_ce2_n,
    input  logic              host_oe_n,
    input  logic              host_we_n,
    input  logic              host_iord_n,
    input  logic              host_iowr_n,
    input  logic              host_reg_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              data_oe,
    input  logic              io_cfg,
    input  logic              irq_req,
    input  logic              irq_pulse_mode,
    output logic [3:0]        rf_addr,
    output logic [1:0]        rf_be,
    output logic              rf_attr,
    output logic              rf_re,
    output logic              rf_we,
    output logic [15:0]       rf_wdata,
    input  logic [15:0]       rf_rdata,
    output logic              rdy_irq,
    output logic              wp_iois16_n,
    output logic [1:0]        cd_n,
    output logic              bvd_spkr,
    output logic              ide_mode
);
    localparam int NSTB = 7;

    logic [NSTB-1:0] stb_sync;
    logic s_ce1_n, s_ce2_n, s_oe_n, s_we_n, s_iord_n, s_iowr_n, s_reg_n;
    logic we_q, iowr_q, irq_q, irq_q2;
    cf_state_e state;
    cf_sel_t   sel [2];
    cf_sel_t   cur;
    logic mem_rd, mem_wr, io_rd, io_wr, use_io, rd_now, wr_now, irq_pulse;

    cfbus_sync #(.W(NSTB)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({host_ce1_n, host_ce2_n, host_oe_n, host_we_n,
            host_iord_n, host_iowr_n, host_reg_n}),
        .q(stb_sync)
    );
    assign {s_ce1_n, s_ce2_n, s_oe_n, s_we_n, s_iord_n, s_iowr_n, s_reg_n} = stb_sync;

    cfbus_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .oe_sync_n(s_oe_n), .io_cfg(io_cfg), .state(state)
    );

    // one decoder per strobe family: 0 = memory strobes, 1 = I/O strobes
    for (genvar k = 0; k < 2; k++) begin : g_dec
        cfbus_decode #(.IO_KIND(k)) u_dec (
            .state(state), .ce1_n(s_ce1_n), .ce2_n(s_ce2_n), .reg_n(s_reg_n),
            .addr(host_addr[4:0]), .sel(sel[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q   <= 1'b1;
            iowr_q <= 1'b1;
            irq_q  <= 1'b0;
            irq_q2 <= 1'b0;
        end else begin
            we_q   <= s_we_n;
            iowr_q <= s_iowr_n;
            irq_q  <= irq_req;
            irq_q2 <= irq_q;
        end
    end

    assign mem_rd    = !s_oe_n;
    assign mem_wr    = s_we_n && !we_q;
    assign io_rd     = !s_iord_n;
    assign io_wr     = s_iowr_n && !iowr_q;
    assign use_io    = io_rd || io_wr;
    assign cur       = use_io ? sel[1] : sel[0];
    assign rd_now    = use_io ? io_rd : mem_rd;
    assign wr_now    = use_io ? io_wr : mem_wr;
    assign irq_pulse = irq_q && !irq_q2;

    assign rf_re    = cur.valid && rd_now;
    assign rf_we    = cur.valid && wr_now;
    assign data_oe  = rf_re;
    assign rf_addr  = cur.idx;
    assign rf_be    = cur.be;
    assign rf_attr  = cur.attr;
    assign rf_wdata = {cur.swap ? host_wdata[7:0] : host_wdata[15:8], host_wdata[7:0]};
    assign host_rdata = {rf_rdata[15:8], cur.swap ? rf_rdata[15:8] : rf_rdata[7:0]};

    assign cd_n     = 2'b00;
    assign bvd_spkr = 1'b1;
    assign ide_mode = (state == ST_IDE);

    always_comb begin
        rdy_irq     = 1'b0;
        wp_iois16_n = 1'b1;
        unique case (state)
            ST_BUSY: begin
                rdy_irq     = 1'b0;
                wp_iois16_n = 1'b1;
            end
            ST_MEM: begin
                rdy_irq     = 1'b1;
                wp_iois16_n = 1'b0;
            end
            ST_IO: begin
                rdy_irq     = irq_pulse_mode ? !irq_pulse : !irq_q;
                wp_iois16_n = !sel[1].word_reg;
            end
            ST_IDE: begin
                rdy_irq     = irq_q;
                wp_iois16_n = !sel[1].word_reg;
            end
            default: ;
        endcase
    end

    logic unused_ok;
    assign unused_ok = ^{host_addr, sel[0].word_reg};

    assert_busy_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> (!rdy_irq && !rf_re && !rf_we));

    assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    assert_attr_low_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rf_re || rf_we) && rf_attr) |-> (rf_be == 2'b01));

    assert_oe_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!s_oe_n || !s_iord_n));

    assert_lanes_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_re || rf_we) |-> (rf_be != 2'b00));
endmodule

// File: tb/cfbus_decoder_tb.sv
`timescale 1ns/1ps
module cfbus_decoder_tb;
    localparam int BUSY = 8;

    typedef struct packed {
        logic [1:0] mode;   // 0 mem, 1 io, 2 ide
        logic       kio;    // 1 = IORD/IOWR strobe
        logic       wr;
        logic       ce1;
        logic       ce2;
        logic       regn;
        logic [4:0] addr;
        logic       ev;
        logic [1:0] ebe;
        logic [3:0] eidx;
        logic       eswap;
        logic       eattr;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,5'd6, 1'b1,2'b11,4'd3,1'b0,1'b0,4'd3}, // R3 word
        '{2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,5'd4, 1'b1,2'b01,4'd2,1'b0,1'b0,4'd3}, // R3 even
        '{2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,5'd5, 1'b1,2'b10,4'd2,1'b1,1'b0,4'd3}, // R3 odd low lane
        '{2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,5'd5, 1'b1,2'b10,4'd2,1'b0,1'b0,4'd3}, // R3 odd high lane
        '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b1,5'd4, 1'b0,2'b00,4'd0,1'b0,1'b0,4'd6}, // R6 no enable
        '{2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,5'd8, 1'b1,2'b01,4'd4,1'b0,1'b1,4'd4}, // R4 attr even
        '{2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,5'd9, 1'b0,2'b00,4'd0,1'b0,1'b0,4'd4}, // R4 attr odd
        '{2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,5'd8, 1'b0,2'b00,4'd0,1'b0,1'b0,4'd4}, // R4 attr ce2
        '{2'd0,1'b0,1'b1,1'b0,1'b0,1'b1,5'd2, 1'b1,2'b11,4'd1,1'b0,1'b0,4'd5}, // R5 word write
        '{2'd0,1'b0,1'b1,1'b0,1'b1,1'b1,5'd7, 1'b1,2'b10,4'd3,1'b1,1'b0,4'd5}, // R5 odd write
        '{2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,5'd0, 1'b0,2'b00,4'd0,1'b0,1'b0,4'd7}, // R7 iord in mem
        '{2'd0,1'b1,1'b1,1'b0,1'b0,1'b0,5'd0, 1'b0,2'b00,4'd0,1'b0,1'b0,4'd7}, // R7 iowr in mem
        '{2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,5'd0, 1'b1,2'b11,4'd0,1'b0,1'b0,4'd7}, // R7 io read
        '{2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,5'd2, 1'b0,2'b00,4'd0,1'b0,1'b0,4'd7}, // R7 reg high
        '{2'd1,1'b1,1'b1,1'b0,1'b1,1'b0,5'd3, 1'b1,2'b10,4'd1,1'b1,1'b0,4'd7}, // R7 io write odd
        '{2'd1,1'b0,1'b0,1'b0,1'b1,1'b0,5'd6, 1'b1,2'b01,4'd3,1'b0,1'b1,4'd4}, // R4 attr in io
        '{2'd2,1'b1,1'b0,1'b0,1'b1,1'b1,5'd0, 1'b1,2'b11,4'd0,1'b0,1'b0,4'd8}, // R8 data reg
        '{2'd2,1'b1,1'b0,1'b0,1'b1,1'b1,5'd3, 1'b1,2'b01,4'd3,1'b0,1'b0,4'd8}, // R8 task reg
        '{2'd2,1'b1,1'b1,1'b0,1'b1,1'b1,5'd5, 1'b1,2'b01,4'd5,1'b0,1'b0,4'd8}, // R8 task write
        '{2'd2,1'b1,1'b0,1'b1,1'b0,1'b1,5'd1, 1'b1,2'b01,4'd8,1'b0,1'b0,4'd8}, // R8 alt reg
        '{2'd2,1'b1,1'b0,1'b0,1'b0,1'b1,5'd0, 1'b0,2'b00,4'd0,1'b0,1'b0,4'd8}, // R8 both low
        '{2'd2,1'b0,1'b1,1'b0,1'b1,1'b1,5'd2, 1'b0,2'b00,4'd0,1'b0,1'b0,4'd8}, // R8 WE ignored
        '{2'd2,1'b0,1'b1,1'b0,1'b1,1'b0,5'd2, 1'b0,2'b00,4'd0,1'b0,1'b0,4'd8}  // R8 WE+REG ignored
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_ce1_n = 1'b1, host_ce2_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
    logic host_iord_n = 1'b1, host_iowr_n = 1'b1, host_reg_n = 1'b1;
    logic [10:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic data_oe, io_cfg = 1'b0, irq_req = 1'b0, irq_pulse_mode = 1'b0;
    logic [3:0] rf_addr;
    logic [1:0] rf_be;
    logic rf_attr, rf_re, rf_we;
    logic [15:0] rf_wdata, rf_rdata;
    logic rdy_irq, wp_iois16_n, bvd_spkr, ide_mode;
    logic [1:0] cd_n;

    int checks = 0, failures = 0, wcount = 0;
    logic [3:0]  cap_addr;
    logic [1:0]  cap_be;
    logic [15:0] cap_wdata;
    logic        cap_attr;
    int cur_mode = 0;

    always #4 clk = ~clk;

    assign rf_rdata = {4'hA, rf_addr, 4'h5, rf_addr};

    cfbus_decoder #(.ADDR_W(11), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_ce1_n(host_ce1_n), .host_ce2_n(host_ce2_n), .host_oe_n(host_oe_n),
        .host_we_n(host_we_n), .host_iord_n(host_iord_n), .host_iowr_n(host_iowr_n),
        .host_reg_n(host_reg_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .data_oe(data_oe), .io_cfg(io_cfg),
        .irq_req(irq_req), .irq_pulse_mode(irq_pulse_mode),
        .rf_addr(rf_addr), .rf_be(rf_be), .rf_attr(rf_attr), .rf_re(rf_re),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .rdy_irq(rdy_irq), .wp_iois16_n(wp_iois16_n), .cd_n(cd_n),
        .bvd_spkr(bvd_spkr), .ide_mode(ide_mode)
    );

    always @(posedge clk) begin
        if (rf_we) begin
            wcount    <= wcount + 1;
            cap_addr  <= rf_addr;
            cap_be    <= rf_be;
            cap_wdata <= rf_wdata;
            cap_attr  <= rf_attr;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic ide);
        rst_n = 1'b0;
        io_cfg = 1'b0;
        host_oe_n = !ide;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (BUSY + 4) @(negedge clk);
        cur_mode = ide ? 2 : 0;
    endtask

    task automatic set_mode(input int m);
        if (m == 2) begin
            if (cur_mode != 2) do_reset(1'b1);
        end else begin
            if (cur_mode == 2) do_reset(1'b0);
            io_cfg = (m == 1);
            repeat (3) @(negedge clk);
            cur_mode = m;
        end
    endtask

    task automatic run_vec(input vec_t v);
        int w0;
        string rq;
        logic [15:0] exp_rd, exp_wd;
        rq = $sformatf("R%0d", v.rq);
        exp_rd = {4'hA, v.eidx, v.eswap ? {4'hA, v.eidx} : {4'h5, v.eidx}};
        exp_wd = {v.eswap ? 8'hC3 : 8'h5A, 8'hC3};
        host_ce1_n = v.ce1; host_ce2_n = v.ce2; host_reg_n = v.regn;
        host_addr = {6'd0, v.addr}; host_wdata = 16'h5AC3;
        @(negedge clk);
        w0 = wcount;
        if (v.kio) begin
            if (v.wr) host_iowr_n = 1'b0; else host_iord_n = 1'b0;
        end else begin
            if (v.wr) host_we_n = 1'b0; else host_oe_n = 1'b0;
        end
        repeat (4) @(negedge clk);
        if (!v.wr) begin
            chk({rq, " data_oe"}, 32'(data_oe), 32'(v.ev));
            chk({rq, " rf_re"}, 32'(rf_re), 32'(v.ev));
            if (v.ev) begin
                chk({rq, " be"}, 32'(rf_be), 32'(v.ebe));
                chk({rq, " index"}, 32'(rf_addr), 32'(v.eidx));
                chk({rq, " attr"}, 32'(rf_attr), 32'(v.eattr));
                chk({rq, " rdata"}, 32'(host_rdata), 32'(exp_rd));
            end
        end else begin
            chk("R5 no write while strobe low", 32'(wcount - w0), 32'd0);
        end
        host_we_n = 1'b1; host_iowr_n = 1'b1; host_iord_n = 1'b1;
        host_oe_n = (cur_mode == 2) ? 1'b0 : 1'b1;
        repeat (4) @(negedge clk);
        if (v.wr) begin
            chk({rq, " write count"}, 32'(wcount - w0), 32'(v.ev));
            if (v.ev) begin
                chk({rq, " write be"}, 32'(cap_be), 32'(v.ebe));
                chk({rq, " write index"}, 32'(cap_addr), 32'(v.eidx));
                chk({rq, " write data"}, 32'(cap_wdata), 32'(exp_wd));
            end
        end
        host_ce1_n = 1'b1; host_ce2_n = 1'b1; host_reg_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic hold_sel(input logic c1, input logic c2, input logic rg, input logic [4:0] a);
        host_ce1_n = c1; host_ce2_n = c2; host_reg_n = rg; host_addr = {6'd0, a};
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // reset state: R1, R11
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(rdy_irq), 32'd0);
        chk("R1 wp high in reset", 32'(wp_iois16_n), 32'd1);
        chk("R6 no data in reset", 32'(data_oe), 32'd0);
        chk("R11 card detect", 32'(cd_n), 32'd0);
        chk("R11 battery pin", 32'(bvd_spkr), 32'd1);
        rst_n = 1'b1;
        repeat (BUSY / 2) @(negedge clk);
        chk("R1 busy after release", 32'(rdy_irq), 32'd0);
        repeat (BUSY) @(negedge clk);
        chk("R1 ready after count", 32'(rdy_irq), 32'd1);
        chk("R2 memory mode", 32'(ide_mode), 32'd0);
        chk("R9 wp low in memory", 32'(wp_iois16_n), 32'd0);

        for (int i = 0; i < NV; i++) begin
            set_mode(int'(VEC[i].mode));
            run_vec(VEC[i]);
        end

        // IDE directed (still in IDE)
        chk("R2 ide latched", 32'(ide_mode), 32'd1);
        chk("R8 oe alone ignored", 32'(data_oe), 32'd0);
        hold_sel(1'b0, 1'b1, 1'b1, 5'd0);
        chk("R9 ide word expected", 32'(wp_iois16_n), 32'd0);
        chk("R8 oe low with ce1 ignored", 32'(data_oe), 32'd0);
        hold_sel(1'b0, 1'b1, 1'b1, 5'd2);
        chk("R9 ide byte reg", 32'(wp_iois16_n), 32'd1);
        hold_sel(1'b1, 1'b1, 1'b1, 5'd0);
        io_cfg = 1'b1;
        irq_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 ide intrq high", 32'(rdy_irq), 32'd1);
        chk("R2 ide ignores io_cfg", 32'(ide_mode), 32'd1);
        irq_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 ide intrq low", 32'(rdy_irq), 32'd0);

        // I/O mode directed
        do_reset(1'b0);
        set_mode(1);
        hold_sel(1'b0, 1'b0, 1'b0, 5'd0);
        chk("R9 io word data reg", 32'(wp_iois16_n), 32'd0);
        hold_sel(1'b0, 1'b1, 1'b0, 5'd0);
        chk("R9 io byte access", 32'(wp_iois16_n), 32'd1);
        hold_sel(1'b1, 1'b1, 1'b1, 5'd0);
        chk("R10 io idle high", 32'(rdy_irq), 32'd1);
        irq_pulse_mode = 1'b0;
        irq_req = 1'b1;
        @(negedge clk);
        chk("R10 level low", 32'(rdy_irq), 32'd0);
        @(negedge clk);
        chk("R10 level held", 32'(rdy_irq), 32'd0);
        irq_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 level release", 32'(rdy_irq), 32'd1);
        irq_pulse_mode = 1'b1;
        irq_req = 1'b1;
        @(negedge clk);
        chk("R10 pulse low", 32'(rdy_irq), 32'd0);
        @(negedge clk);
        chk("R10 pulse one clock", 32'(rdy_irq), 32'd1);
        irq_req = 1'b0;
        io_cfg = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 back to memory", 32'(wp_iois16_n), 32'd0);
        chk("R2 memory ready", 32'(rdy_irq), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule